// File: doc/BRIEF.md
# Double-Buffered Control Register Bank

This block holds the configuration registers of a signal-synthesis core. A byte-wide write port loads one byte at a time into a register chosen by an address and a byte index. Registers do not all have the same width: each location has its own depth of two, four or eight bytes. Writes land only in a shadow copy. The active copy, which drives the downstream datapath, is refreshed from the whole shadow bank at once. This happens on a clock edge where the update input is high, or on a clock edge where the profile select input differs from its registered value.

A small set of fields bypass the buffer. The four-bit profile control field of the first control register reaches the active copy on the write itself. Two locations in the map are unused. Writes to them and to addresses past the map are dropped, and they read as zero. Two combinational read ports expose the shadow and active contents of any address. The active first control register is also presented as a dedicated output.

Top module: `shadow_reg_bank`

## Requirements
- R1: After reset, every location reads zero on both the shadow and the active read ports, and `ctrl0_o` and `prof_ctrl_o` are zero.
- R2: A byte write updates the shadow copy at the clock edge. The active copy keeps its value while no commit occurs. Byte index 0 holds bits 7:0, and byte index k holds bits 8k+7:8k.
- R3: A clock edge with `update_i` high copies every shadow register into the active copy.
- R4: A clock edge where `profile_i` differs from its value at the previous edge copies every shadow register into the active copy. A steady `profile_i` commits nothing.
- R5: Addresses 5 and 6, and addresses 24 and above, hold no storage. Writes to them change nothing, and both read ports return zero for them.
- R6: Register depths are as follows: address 8 has 2 bytes; addresses 11 through 21 have 8 bytes; all other used addresses have 4 bytes. A write whose byte index is at or beyond the depth is ignored.
- R7: Bits 20:17 of address 0 (byte index 2, bits 4:1) reach the active copy and `prof_ctrl_o` at the edge of the write with no commit. The other bits of that byte wait for a commit.
- R8: When a write and a commit share an edge, the byte just written is included in the transfer.
- R9: `ctrl0_o` always equals bits 31:0 of the active copy of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 5 | Register address of the write |
| wr_byte_i | input | 3 | Byte index within the register, 0 = least significant |
| wr_data_i | input | 8 | Byte to write |
| update_i | input | 1 | Commit strobe, sampled at the clock edge |
| profile_i | input | 3 | Profile select; any change commits |
| rd_addr_i | input | 5 | Read address for both read ports |
| rd_shadow_o | output | 64 | Shadow contents at `rd_addr_i`, zero-extended |
| rd_active_o | output | 64 | Active contents at `rd_addr_i`, zero-extended |
| ctrl0_o | output | 32 | Active copy of address 0 |
| prof_ctrl_o | output | 4 | Active bits 20:17 of address 0 |

## Verification
The bench builds the block with its default parameters: a 5-bit address, a 3-bit profile select and eight-byte maximum depth. With these values the bench can reach the short two-byte register, the eight-byte registers, both unused holes and the addresses past the map. The byte-index boundary is tested on a short register, where indices at or beyond its depth are dropped. The commit paths are also tested against each other: update strobe, profile edge, steady profile, the immediate field, and a write landing on the same edge as a commit.

// File: rtl/shadow_reg_pkg.sv
package shadow_reg_pkg;

  localparam int NUM_REGS  = 24;
  localparam int MAX_BYTES = 8;
  localparam int REG_W     = MAX_BYTES * 8;
  localparam int BIDX_W    = $clog2(MAX_BYTES);

  typedef logic [REG_W-1:0] reg_word_t;

  // Byte depth of each location; zero marks a hole in the map.
  function automatic int reg_bytes(input int unsigned loc);
    if (loc == 5 || loc == 6 || loc >= NUM_REGS) return 0;
    if (loc == 8)                                return 2;
    if (loc >= 11 && loc <= 21)                  return 8;
    return 4;
  endfunction

  // Bits that reach the active copy on the write itself.
  function automatic reg_word_t bypass_mask(input int unsigned loc);
    reg_word_t m;
    m = '0;
    if (loc == 0) m[20:17] = 4'hF;
    return m;
  endfunction

  // Bits that exist for a given depth.
  function automatic reg_word_t depth_mask(input int depth);
    reg_word_t m;
    m = '0;
    for (int b = 0; b < MAX_BYTES; b++) begin
      if (b < depth) m[b*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/bank_wr_decode.sv
module bank_wr_decode
  import shadow_reg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BIDX_W-1:0] wr_byte_i,
  output logic [NUM_REGS-1:0] hit_o
);

  always_comb begin
    hit_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (wr_en_i && (int'(wr_addr_i) == i) && (reg_bytes(i) > 0)
          && (int'(wr_byte_i) < reg_bytes(i))) begin
        hit_o[i] = 1'b1;
      end
    end
  end

  // R5
  hole_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_addr_i == ADDR_W'(5) || wr_addr_i == ADDR_W'(6)) |-> (hit_o == '0));

  // R6
  short_reg_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_addr_i == ADDR_W'(8) && wr_byte_i >= BIDX_W'(2)) |-> (hit_o == '0));

endmodule

// File: rtl/bank_slot.sv
module bank_slot
  import shadow_reg_pkg::*;
#(
  parameter int        DEPTH    = 4,
  parameter reg_word_t BYP_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              hit_i,
  input  logic [BIDX_W-1:0] byte_i,
  input  logic [7:0]        data_i,
  input  logic              commit_i,
  output reg_word_t         shadow_o,
  output reg_word_t         active_o
);

  localparam reg_word_t DMASK = depth_mask(DEPTH);

  reg_word_t sh_q, sh_d;
  reg_word_t ac_q, ac_d;
  logic      sh_en, ac_en;

  always_comb begin
    sh_d = sh_q;
    if (hit_i) sh_d[{byte_i, 3'b000} +: 8] = data_i;
    sh_d  = sh_d & DMASK;
    sh_en = hit_i;
  end

  always_comb begin
    ac_d = ac_q;
    if (commit_i) begin
      ac_d = sh_d;
    end else if (hit_i) begin
      ac_d = (ac_q & ~BYP_MASK) | (sh_d & BYP_MASK);
    end
    ac_en = commit_i | hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ac_q <= '0;
    end else if (ac_en) begin
      ac_q <= ac_d;
    end
  end

  assign shadow_o = sh_q;
  assign active_o = ac_q;

  // R2
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!commit_i && !hit_i) |=> $stable(ac_q));

  // R3
  commit_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    commit_i |=> (ac_q == sh_q));

  // R6
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((sh_q & ~DMASK) == '0) && ((ac_q & ~DMASK) == '0));

  // R7
  bypass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    hit_i |=> ((ac_q & BYP_MASK) == (sh_q & BYP_MASK)));

endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
  import shadow_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PROF_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [2:0]        wr_byte_i,
  input  logic [7:0]        wr_data_i,
  input  logic              update_i,
  input  logic [PROF_W-1:0] profile_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [63:0]       rd_shadow_o,
  output logic [63:0]       rd_active_o,
  output logic [31:0]       ctrl0_o,
  output logic [3:0]        prof_ctrl_o
);

  logic rst_n;
  logic [NUM_REGS-1:0] hit;
  logic [PROF_W-1:0]   prof_q;
  logic                prof_edge;
  logic                commit;
  reg_word_t           sh_arr [NUM_REGS];
  reg_word_t           ac_arr [NUM_REGS];

  bank_rst_sync i_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (rst_n_i),
    .rst_n_o  (rst_n)
  );

  bank_wr_decode #(.ADDR_W(ADDR_W)) i_decode (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_byte_i (wr_byte_i),
    .hit_o     (hit)
  );

  always_comb begin
    prof_edge = (profile_i != prof_q);
    commit    = update_i | prof_edge;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      prof_q <= '0;
    end else begin
      prof_q <= profile_i;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_loc
    localparam int DEP = reg_bytes(g);
    if (DEP > 0) begin : g_used
      bank_slot #(
        .DEPTH    (DEP),
        .BYP_MASK (bypass_mask(g))
      ) i_slot (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n),
        .hit_i    (hit[g]),
        .byte_i   (wr_byte_i),
        .data_i   (wr_data_i),
        .commit_i (commit),
        .shadow_o (sh_arr[g]),
        .active_o (ac_arr[g])
      );
    end else begin : g_hole
      assign sh_arr[g] = '0;
      assign ac_arr[g] = '0;
    end
  end

  always_comb begin
    rd_shadow_o = '0;
    rd_active_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(rd_addr_i) == i) begin
        rd_shadow_o = sh_arr[i];
        rd_active_o = ac_arr[i];
      end
    end
  end

  assign ctrl0_o     = ac_arr[0][31:0];
  assign prof_ctrl_o = ac_arr[0][20:17];

  // R5
  hole_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_addr_i == ADDR_W'(5) || rd_addr_i == ADDR_W'(6) || int'(rd_addr_i) >= NUM_REGS)
      |-> (rd_shadow_o == '0 && rd_active_o == '0));

  // R4
  profile_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (profile_i != prof_q) |=> (ac_arr[1] == sh_arr[1]));

  // R8
  coincide_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hit[1] && update_i) |=> (ac_arr[1] == sh_arr[1]));

endmodule

// File: tb/test_shadow_reg_bank.sv
module test_shadow_reg_bank;

  logic        clk_i = 1'b0;
  logic        rst_n_i;
  logic        wr_en_i;
  logic [4:0]  wr_addr_i;
  logic [2:0]  wr_byte_i;
  logic [7:0]  wr_data_i;
  logic        update_i;
  logic [2:0]  profile_i;
  logic [4:0]  rd_addr_i;
  logic [63:0] rd_shadow_o;
  logic [63:0] rd_active_o;
  logic [31:0] ctrl0_o;
  logic [3:0]  prof_ctrl_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  shadow_reg_bank i_shadow_reg_bank (
    .clk_i, .rst_n_i, .wr_en_i, .wr_addr_i, .wr_byte_i, .wr_data_i,
    .update_i, .profile_i, .rd_addr_i, .rd_shadow_o, .rd_active_o,
    .ctrl0_o, .prof_ctrl_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [4:0] a, output logic [63:0] sh, output logic [63:0] ac);
    rd_addr_i = a;
    #0.5;
    sh = rd_shadow_o;
    ac = rd_active_o;
  endtask

  task automatic wr(input logic [4:0] a, input logic [2:0] b, input logic [7:0] d, input logic upd);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_byte_i = b; wr_data_i = d; update_i = upd;
    @(negedge clk_i);
    wr_en_i = 1'b0; update_i = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk_i);
    update_i = 1'b1;
    @(negedge clk_i);
    update_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] s, a;
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < 32; i++) begin
      peek(5'(i), s, a);
      acc = acc | s | a;
    end
    check("R1 all locations zero", acc, 64'h0);
    check("R1 ctrl0 zero", {32'h0, ctrl0_o}, 64'h0);
    check("R1 prof_ctrl zero", {60'h0, prof_ctrl_o}, 64'h0);
  endtask

  task automatic t_shadow_write();
    logic [63:0] s, a;
    wr(5'd1, 3'd0, 8'hA5, 1'b0);
    wr(5'd1, 3'd3, 8'h3C, 1'b0);
    repeat (2) @(negedge clk_i);
    peek(5'd1, s, a);
    check("R2 shadow bytes placed", s, 64'h0000_0000_3C00_00A5);
    check("R2 active untouched", a, 64'h0);
  endtask

  task automatic t_update();
    logic [63:0] s, a;
    wr(5'd14, 3'd7, 8'h81, 1'b0);
    pulse_update();
    peek(5'd1, s, a);
    check("R3 addr1 committed", a, 64'h0000_0000_3C00_00A5);
    peek(5'd14, s, a);
    check("R3 addr14 committed top byte", a, 64'h8100_0000_0000_0000);
  endtask

  task automatic t_profile();
    logic [63:0] s, a;
    wr(5'd9, 3'd1, 8'h77, 1'b0);
    repeat (3) @(negedge clk_i);
    peek(5'd9, s, a);
    check("R4 steady profile no commit", a, 64'h0);
    @(negedge clk_i);
    profile_i = 3'd5;
    @(negedge clk_i);
    peek(5'd9, s, a);
    check("R4 profile change commits", a, 64'h0000_0000_0000_7700);
    wr(5'd9, 3'd0, 8'h11, 1'b0);
    @(negedge clk_i);
    peek(5'd9, s, a);
    check("R4 held profile no second commit", a, 64'h0000_0000_0000_7700);
  endtask

  task automatic t_unused();
    logic [63:0] s, a;
    wr(5'd5, 3'd0, 8'hFF, 1'b1);
    wr(5'd6, 3'd1, 8'hEE, 1'b1);
    wr(5'd25, 3'd0, 8'hDD, 1'b1);
    peek(5'd5, s, a);
    check("R5 addr5 reads zero", s | a, 64'h0);
    peek(5'd6, s, a);
    check("R5 addr6 reads zero", s | a, 64'h0);
    peek(5'd25, s, a);
    check("R5 addr25 reads zero", s | a, 64'h0);
    peek(5'd4, s, a);
    check("R5 neighbour addr4 untouched", s | a, 64'h0);
    peek(5'd7, s, a);
    check("R5 neighbour addr7 untouched", s | a, 64'h0);
  endtask

  task automatic t_depth();
    logic [63:0] s, a;
    wr(5'd8, 3'd1, 8'h5A, 1'b0);
    wr(5'd8, 3'd2, 8'hC3, 1'b0);
    wr(5'd8, 3'd7, 8'hC3, 1'b0);
    peek(5'd8, s, a);
    check("R6 two-byte reg drops index>=2", s, 64'h0000_0000_0000_5A00);
    wr(5'd2, 3'd4, 8'h99, 1'b0);
    peek(5'd2, s, a);
    check("R6 four-byte reg drops index 4", s, 64'h0);
    wr(5'd21, 3'd5, 8'h42, 1'b0);
    peek(5'd21, s, a);
    check("R6 eight-byte reg keeps index 5", s, 64'h0000_4200_0000_0000);
  endtask

  task automatic t_immediate();
    logic [63:0] s, a;
    wr(5'd0, 3'd2, 8'hFF, 1'b0);
    peek(5'd0, s, a);
    check("R7 shadow byte 2", s, 64'h0000_0000_00FF_0000);
    check("R7 only bits 20:17 active", a, 64'h0000_0000_001E_0000);
    check("R7 prof_ctrl immediate", {60'h0, prof_ctrl_o}, 64'hF);
    check("R9 ctrl0 follows active", {32'h0, ctrl0_o}, 64'h0000_0000_001E_0000);
    wr(5'd0, 3'd2, 8'h0A, 1'b0);
    check("R7 prof_ctrl rewritten", {60'h0, prof_ctrl_o}, 64'h5);
    check("R7 other bits still held", {32'h0, ctrl0_o}, 64'h0000_0000_001E_0000 & ~64'h1E_0000 | 64'h0A_0000);
    pulse_update();
    check("R9 ctrl0 after commit", {32'h0, ctrl0_o}, 64'h0000_0000_000A_0000);
  endtask

  task automatic t_coincide();
    logic [63:0] s, a;
    wr(5'd1, 3'd1, 8'h6B, 1'b1);
    peek(5'd1, s, a);
    check("R8 new byte in same-edge commit", a, 64'h0000_0000_3C00_6BA5);
    check("R8 shadow matches", s, 64'h0000_0000_3C00_6BA5);
  endtask

  initial begin
    rst_n_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_byte_i = '0;
    wr_data_i = '0; update_i = 1'b0; profile_i = '0; rd_addr_i = '0;
    repeat (3) @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_shadow_write();
    t_update();
    t_profile();
    t_unused();
    t_depth();
    t_immediate();
    t_coincide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule